// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Update Controller

This block is the host side of a string of serial-input DACs wired in a daisy chain. All devices share one serial clock and one active-low select/load line. The controller drives a single data line into the first device, and each device passes its shift-register output on to the next one. The controller takes one 14-bit code per device on a parallel bus, and a start strobe launches the transfer. It then streams one long serial word under a single select/load assertion. The word holds one 16-bit frame per device: the code, most significant bit first, followed by two padding bits driven as zero. The frame for the farthest device goes out first, so after the last bit every device holds its own code. Select/load then rises once, and every converter updates on that same edge.

The serial bit rate comes from a divider parameter that sets the half-period of the serial clock in system clock cycles. The serial clock is held low whenever select/load is high or changes. A setup gap of at least one full serial period comes before the first rising edge, and an equal gap comes after the last falling edge. Data changes only while the serial clock is low. While a transfer runs, the controller shows busy and ignores further start strobes. A one-cycle done pulse marks the load edge.

Top module: `dac_chain_host`

## Requirements
- R1: After reset, sel_n is 1, sclk is 0, sdata is 0, busy is 0 and done is 0.
- R2: sclk is 0 whenever sel_n is 1 and in the cycle sel_n falls or rises; sclk rises only while sel_n is 0.
- R3: Each device receives a 16-bit frame, most significant bit first: its 14-bit code in frame bits 15..2, then frame bits 1..0 equal to 0.
- R4: codes_i[k*14 +: 14] is the code of device k, where device 0 is the one wired to sdata; the frame of device N_DEV-1 is sent first and the frame of device 0 last.
- R5: Each transfer has exactly N_DEV*16 rising sclk edges, and sdata does not change while sclk is high.
- R6: At least 2*HALF_DIV clk cycles pass from the fall of sel_n to the first rising sclk edge, and from the last falling sclk edge to the rise of sel_n.
- R7: Within a transfer, every sclk high phase and low phase between two sclk edges lasts exactly HALF_DIV clk cycles.
- R8: sel_n rises once per transfer. In the same cycle done is 1 for exactly one cycle and busy is 0.
- R9: A start while busy is 1 is ignored. The codes are captured in the cycle start is accepted, so later changes to codes_i do not affect the transfer in progress.
- R10: busy is 1 from the cycle after an accepted start until the cycle done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer; accepted only when not busy |
| codes_i | input | N_DEV*CODE_W | Packed codes, device k at bits k*CODE_W +: CODE_W |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the load edge |
| sclk | output | 1 | Shared serial clock, devices sample on its rising edge |
| sel_n | output | 1 | Shared active-low select, rising edge loads all devices |
| sdata | output | 1 | Serial data into the first device of the chain |

## Verification
The bench models the chain as linked 16-bit shift registers that latch on the rise of sel_n, and compares each device's latched frame with its own code and zero padding. Codes that are all zeros and all ones show whether the padding is zero and whether the frame is aligned. Alternating patterns and a code that differs for each device expose bit-order and device-order swaps. Random codes cover the rest. Separate runs change codes_i just after acceptance and pulse start in the middle of a transfer, and the transfer in progress must not change in either case. A timing monitor measures the gaps, the half periods and the count of rising edges against the divider.

// File: rtl/dac_chain_pkg.sv
`timescale 1ns/1ps
package dac_chain_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_HOLD  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/dac_chain_tick.sv
`timescale 1ns/1ps
module dac_chain_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   // R7: the divider never passes its terminal count
   a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/dac_chain_shreg.sv
`timescale 1ns/1ps
module dac_chain_shreg #(
   parameter int N_DEV   = 3,
   parameter int CODE_W  = 14,
   parameter int FRAME_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [N_DEV*CODE_W-1:0]   codes_i,
   input  logic                      shift,
   output logic                      sdata
);
   localparam int TOT_W = N_DEV * FRAME_W;
   localparam int PAD_W = FRAME_W - CODE_W;

   logic [TOT_W-1:0] frames;
   logic [TOT_W-1:0] word_q;

   // Device k occupies frame slot k; slot N_DEV-1 sits at the MSB end and leaves first (R4)
   for (genvar k = 0; k < N_DEV; k++) begin : g_frame
      if (PAD_W > 0) begin : g_pad
         assign frames[k*FRAME_W +: FRAME_W] = {codes_i[k*CODE_W +: CODE_W], {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign frames[k*FRAME_W +: FRAME_W] = codes_i[k*CODE_W +: CODE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (load)  word_q <= frames;
      else if (shift) word_q <= {word_q[TOT_W-2:0], 1'b0};
   end

   assign sdata = word_q[TOT_W-1];

   // R9: the captured word moves only on load or shift
   a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(word_q));
endmodule

// File: rtl/dac_chain_seq.sv
`timescale 1ns/1ps
module dac_chain_seq
   import dac_chain_pkg::*;
#(
   parameter int N_DEV   = 3,
   parameter int FRAME_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic accept,
   output logic shift,
   output logic sclk,
   output logic sel_n,
   output logic busy,
   output logic done
);
   localparam int TOT_BITS = N_DEV * FRAME_W;
   localparam int BW = $clog2(TOT_BITS);
   localparam logic [BW-1:0] LAST_BIT = BW'(TOT_BITS - 1);

   seq_state_e    state_q;
   logic [BW-1:0] bit_q;
   logic          ph_q;
   logic          sclk_q, sel_q, done_q;

   assign accept = start && (state_q == ST_IDLE);
   assign shift  = (state_q == ST_SHIFT) && tick && sclk_q;
   assign busy   = (state_q != ST_IDLE);
   assign sclk   = sclk_q;
   assign sel_n  = sel_q;
   assign done   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         ph_q    <= 1'b0;
         sclk_q  <= 1'b0;
         sel_q   <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_SETUP;
                  sel_q   <= 1'b0;
                  bit_q   <= '0;
                  ph_q    <= 1'b0;
               end
            end
            ST_SETUP: begin
               if (tick) state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_q == LAST_BIT) begin
                        state_q <= ST_HOLD;
                        bit_q   <= '0;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  if (ph_q) begin
                     state_q <= ST_IDLE;
                     sel_q   <= 1'b1;
                     done_q  <= 1'b1;
                     ph_q    <= 1'b0;
                  end else begin
                     ph_q <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R10: an accepted start makes the block busy in the next cycle
   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   // R9: a start while busy does not restart the sequence
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !sel_q) |=> (busy || done_q));
endmodule

// File: rtl/dac_chain_host.sv
`timescale 1ns/1ps
module dac_chain_host #(
   parameter int N_DEV    = 3,
   parameter int CODE_W   = 14,
   parameter int FRAME_W  = 16,
   parameter int HALF_DIV = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [N_DEV*CODE_W-1:0] codes_i,
   output logic                    busy,
   output logic                    done,
   output logic                    sclk,
   output logic                    sel_n,
   output logic                    sdata
);
   if (N_DEV < 1) begin : g_bad_n
      $error("N_DEV must be at least 1");
   end
   if (CODE_W < 1 || CODE_W > FRAME_W) begin : g_bad_w
      $error("CODE_W must lie in 1..FRAME_W");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic tick, accept, shift;

   dac_chain_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick)
   );

   dac_chain_seq #(.N_DEV(N_DEV), .FRAME_W(FRAME_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .accept(accept), .shift(shift), .sclk(sclk), .sel_n(sel_n),
      .busy(busy), .done(done)
   );

   dac_chain_shreg #(.N_DEV(N_DEV), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(accept), .codes_i(codes_i),
      .shift(shift), .sdata(sdata)
   );

   // R2: clock is parked low while deselected and at both select edges
   a_r2_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> !sclk);
   a_r2_sel_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> !sclk);
   // R5: data holds while the clock is high
   a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdata));
   // R8: done is a single-cycle pulse coinciding with the load edge
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_at_load: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($rose(sel_n) && !busy));
endmodule

// File: tb/dac_chain_host_bench.sv
`timescale 1ns/1ps
module dac_chain_host_bench;
   localparam int N   = 3;
   localparam int CW  = 14;
   localparam int FW  = 16;
   localparam int H   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N*CW-1:0] codes = '0;
   logic busy, done, sclk, sel_n, sdata;

   int checks = 0;
   int failures = 0;
   int done_cnt = 0;

   logic [FW-1:0] chain [N];
   logic [FW-1:0] latched [N];

   always #5 clk = ~clk;

   dac_chain_host #(.N_DEV(N), .CODE_W(CW), .FRAME_W(FW), .HALF_DIV(H)) u_dac_chain_host (
      .clk(clk), .rst_n(rst_n), .start(start), .codes_i(codes),
      .busy(busy), .done(done), .sclk(sclk), .sel_n(sel_n), .sdata(sdata)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] exp_frame(input logic [N*CW-1:0] c, input int k);
      return {c[k*CW +: CW], {(FW-CW){1'b0}}};
   endfunction

   // Chain model and timing monitor, sampled away from the active edge
   logic p_sclk = 1'b0, p_sel = 1'b1, p_sdata = 1'b0, p_done = 1'b0;
   int   since = 0, rises = 0;
   bit   first = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_sclk = 1'b0; p_sel = 1'b1; p_sdata = 1'b0; p_done = 1'b0;
         since = 0; rises = 0; first = 1'b0;
      end else begin
         since++;
         if (!sel_n && p_sel) begin
            check(!sclk, "R2 sclk low at select fall", sclk, 0);
            rises = 0; since = 0; first = 1'b1;
         end
         if (sclk && !p_sclk) begin
            check(!sel_n, "R2 rise only while selected", sel_n, 0);
            if (first) check(since >= 2*H, "R6 setup gap", since, 2*H);
            else       check(since == H, "R7 low phase", since, H);
            first = 1'b0;
            rises++;
            for (int k = N-1; k >= 1; k--) chain[k] = {chain[k][FW-2:0], chain[k-1][FW-1]};
            chain[0] = {chain[0][FW-2:0], sdata};
            since = 0;
         end
         if (!sclk && p_sclk) begin
            check(since == H, "R7 high phase", since, H);
            since = 0;
         end
         if (sclk && p_sclk)
            check(sdata == p_sdata, "R5 data stable while high", sdata, p_sdata);
         if (sel_n && !p_sel) begin
            check(!sclk, "R2 sclk low at load", sclk, 0);
            check(since >= 2*H, "R6 hold gap", since, 2*H);
            check(rises == N*FW, "R5 rising edge count", rises, N*FW);
            for (int k = 0; k < N; k++) latched[k] = chain[k];
         end
         if (done) begin
            done_cnt++;
            check(sel_n && !p_sel, "R8 done with load edge", {sel_n, p_sel}, 2'b10);
            check(!busy, "R8 busy clear at done", busy, 0);
            check(!p_done, "R8 done single cycle", p_done, 0);
         end
         p_sclk = sclk; p_sel = sel_n; p_sdata = sdata; p_done = done;
      end
   end

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1'b1; break; end
      end
      check(ok, "R8 done reached", ok, 1);
   endtask

   task automatic run(input logic [N*CW-1:0] c, input string tag, input bit disturb);
      bit ok;
      int d0;
      d0 = done_cnt;
      @(negedge clk);
      codes = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R10 busy after accept", busy, 1);
      if (disturb) begin
         codes = ~c;                              // R9 codes captured at accept
         repeat (40) @(negedge clk);
         codes = {N{14'h1555}} ^ c; start = 1'b1; // R9 start while busy
         @(negedge clk);
         start = 1'b0;
         check(busy, "R9 still busy after ignored start", busy, 1);
      end
      wait_done(ok);
      @(negedge clk);
      check(!busy, "R10 busy clear after done", busy, 0);
      check(done_cnt == d0 + 1, "R9 one load per transfer", done_cnt - d0, 1);
      for (int k = 0; k < N; k++) begin
         check(latched[k][FW-1:FW-CW] == c[k*CW +: CW], {"R4 device code ", tag},
               latched[k][FW-1:FW-CW], c[k*CW +: CW]);
         check(latched[k] == exp_frame(c, k), {"R3 frame and padding ", tag},
               latched[k], exp_frame(c, k));
      end
      // R9: no second transfer starts after the ignored strobe
      repeat (4*H + 4) @(negedge clk);
      check(sel_n && !busy, "R9 stays idle", {sel_n, busy}, 2'b10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [N*CW-1:0] c;
      void'($urandom(32'h5eed1234));
      for (int k = 0; k < N; k++) begin chain[k] = '0; latched[k] = '0; end
      repeat (3) @(negedge clk);
      check(sel_n == 1'b1, "R1 reset sel_n", sel_n, 1);
      check(sclk == 1'b0, "R1 reset sclk", sclk, 0);
      check(sdata == 1'b0, "R1 reset sdata", sdata, 0);
      check(busy == 1'b0, "R1 reset busy", busy, 0);
      check(done == 1'b0, "R1 reset done", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run('0, "zeros", 1'b0);
      run('1, "ones", 1'b0);
      run({N{14'h2AAA}}, "alt_a", 1'b0);
      run({N{14'h1555}}, "alt_5", 1'b0);
      for (int k = 0; k < N; k++) c[k*CW +: CW] = CW'(14'h0101 * (k + 1) + k);
      run(c, "per_device", 1'b0);
      run(c, "latch_and_ignore", 1'b1);
      for (int i = 0; i < 12; i++) begin
         for (int k = 0; k < N; k++) c[k*CW +: CW] = CW'($urandom);
         run(c, "random", (i % 4) == 3);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule